// File: doc/BRIEF.md
# Workgroup Barrier Slot Pool

This block keeps a fixed pool of hardware barrier slots for a compute unit whose wavefronts are grouped into workgroups. A dispatcher takes a slot when it launches a workgroup and states how many wavefronts will take part. Each wavefront reports when it reaches the barrier. The block shows, for each slot, whether every participant has arrived, and for one queried slot it shows the arrived count, the participant limit and how many wavefronts are still missing.

The participant limit can shrink while the slot is in use, because a wavefront that exits leaves the barrier. Re-arming a slot for its workgroup's next barrier only clears the arrived count and keeps the limit. Freeing the slot is a separate command: it clears both counters and returns the ID to the pool. Commands arrive one per cycle on a single port. The all-ones slot ID stands for "no barrier" and is never granted. A command that is not legal sets a sticky error flag and changes no state.

Top module: `wg_barrier_pool`

## Requirements
- R1: After reset all slots are free, `free_count` equals NUM_SLOTS, `grant_valid` is 0, `grant_id` is all ones, `err_sticky` is 0 and `sat_vec` is 0.
- R2: An allocate command (op 1) with `cmd_count` at most MAX_WAVES takes the lowest-numbered free slot. In the next cycle `grant_valid` is 1 for one cycle with that ID on `grant_id`, the slot has limit `cmd_count` and arrived count 0, and `free_count` is one lower. `grant_id` holds its value until the next allocate.
- R3: The all-ones ID is never granted. An allocate with no free slot gives no grant, sets `grant_id` to all ones and raises the error flag.
- R4: An arrive command (op 2) adds one to the slot's arrived count. When the arrived count already equals the limit, the command is illegal.
- R5: Bit i of `sat_vec` is 1 exactly when slot i is allocated and its arrived count equals its limit. The bit changes in the cycle after the command that changes the counters.
- R6: `q_missing` equals the queried slot's limit minus its arrived count.
- R7: A leave command (op 3) lowers the limit by one. If the arrived count equals the limit, the arrived count is lowered too, so the arrived count never exceeds the limit. A leave at limit 0 is illegal.
- R8: A re-arm command (op 4) clears the arrived count and keeps the limit.
- R9: A free command (op 5) clears both counters, returns the slot to the pool, and the slot can be granted again in lowest-first order.
- R10: These commands are illegal: an ID of NUM_SLOTS or above (the all-ones ID included), a command other than allocate to a slot that is not allocated, an allocate count above MAX_WAVES, and op codes 6 and 7. An illegal command sets `err_sticky` and leaves every counter, the pool and the grant outputs unchanged.
- R11: `err_sticky` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | 0 none, 1 allocate, 2 arrive, 3 leave, 4 re-arm, 5 free |
| cmd_id | input | SID_W | Target slot ID (not used by allocate) |
| cmd_count | input | CNT_W | Participant count for allocate |
| grant_valid | output | 1 | One-cycle pulse after a successful allocate |
| grant_id | output | SID_W | Last granted slot, all ones if none |
| q_id | input | SID_W | Slot selected for the query outputs |
| q_allocated | output | 1 | Queried slot is in use |
| q_arrived | output | CNT_W | Arrived count of the queried slot |
| q_limit | output | CNT_W | Participant limit of the queried slot |
| q_missing | output | CNT_W | Participants still missing |
| sat_vec | output | NUM_SLOTS | Per-slot all-arrived flags |
| free_count | output | FC_W | Number of free slots |
| err_sticky | output | 1 | Sticky illegal-command flag |

## Verification
Every command is taken on the rising edge where it is present. Its effect on the counters, the pool, `sat_vec`, the grant pulse and the error flag is due right after that edge. The bench drives a command on a falling edge and removes it just after the rising edge. It then reads all results on the next falling edge, which is one edge after the command was taken. The query outputs are combinational views of the registered state, so the bench sets `q_id` together with the command and reads the new values in the same falling-edge sample.

// File: rtl/wgb_pkg.sv
package wgb_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_ARRIVE  = 3'd2,
    OP_LEAVE   = 3'd3,
    OP_REARM   = 3'd4,
    OP_RELEASE = 3'd5
  } wgb_op_e;

  typedef struct packed {
    logic load;
    logic arrive;
    logic leave;
    logic rearm;
    logic clear;
  } wgb_slot_cmd_t;

endpackage

// File: rtl/wgb_free_pool.sv
module wgb_free_pool #(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 2,
  parameter int FC_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 give,
  input  logic [IDX_W-1:0]     give_idx,
  output logic [NUM_SLOTS-1:0] free_mask,
  output logic                 any_free,
  output logic [IDX_W-1:0]     low_idx,
  output logic [FC_W-1:0]      free_count
);

  // lowest set bit of the free mask
  function automatic logic [IDX_W-1:0] lowest_free(input logic [NUM_SLOTS-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [FC_W-1:0] count_free(input logic [NUM_SLOTS-1:0] m);
    logic [FC_W-1:0] c;
    c = '0;
    for (int i = 0; i < NUM_SLOTS; i++) c = c + FC_W'(m[i]);
    return c;
  endfunction

  assign low_idx    = lowest_free(free_mask);
  assign any_free   = |free_mask;
  assign free_count = count_free(free_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_mask <= '1;
    end else begin
      if (take) free_mask[low_idx]  <= 1'b0;
      if (give) free_mask[give_idx] <= 1'b1;
    end
  end

endmodule

// File: rtl/wgb_slot.sv
module wgb_slot
  import wgb_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wgb_slot_cmd_t    cmd,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] arrived,
  output logic [CNT_W-1:0] limit
);

  logic all_in;
  assign all_in = (arrived == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arrived <= '0;
      limit   <= '0;
    end else if (cmd.load) begin
      arrived <= '0;
      limit   <= load_val;
    end else if (cmd.clear) begin
      arrived <= '0;
      limit   <= '0;
    end else if (cmd.rearm) begin
      arrived <= '0;
    end else if (cmd.arrive) begin
      arrived <= arrived + CNT_W'(1);
    end else if (cmd.leave) begin
      limit <= limit - CNT_W'(1);
      // the leaver had already been counted as arrived
      if (all_in) arrived <= arrived - CNT_W'(1);
    end
  end

endmodule

// File: rtl/wgb_decode.sv
module wgb_decode
  import wgb_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int MAX_WAVES = 16,
  parameter int SID_W     = 3,
  parameter int IDX_W     = 2,
  parameter int CNT_W     = 5
) (
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [SID_W-1:0]     cmd_id,
  input  logic [CNT_W-1:0]     cmd_count,
  input  logic [NUM_SLOTS-1:0] free_mask,
  input  logic                 any_free,
  input  logic [IDX_W-1:0]     low_idx,
  input  logic [CNT_W-1:0]     tgt_arrived,
  input  logic [CNT_W-1:0]     tgt_limit,
  output logic [IDX_W-1:0]     tgt_idx,
  output wgb_slot_cmd_t        tgt_cmd,
  output logic                 ok_fire,
  output logic                 bad_fire,
  output logic                 take,
  output logic                 give
);

  localparam logic [SID_W-1:0] NSLOT = SID_W'(NUM_SLOTS);
  localparam logic [CNT_W-1:0] MAXW  = CNT_W'(MAX_WAVES);

  logic    in_range, in_use, legal;
  wgb_op_e op;

  assign op       = wgb_op_e'(cmd_op);
  assign in_range = (cmd_id < NSLOT);
  assign in_use   = in_range && !free_mask[cmd_id[IDX_W-1:0]];
  assign tgt_idx  = (op == OP_ALLOC) ? low_idx : cmd_id[IDX_W-1:0];

  always_comb begin
    legal = 1'b0;
    unique case (op)
      OP_ALLOC:   legal = any_free && (cmd_count <= MAXW);
      OP_ARRIVE:  legal = in_use && (tgt_arrived < tgt_limit);
      OP_LEAVE:   legal = in_use && (tgt_limit != '0);
      OP_REARM:   legal = in_use;
      OP_RELEASE: legal = in_use;
      default:    legal = 1'b0;
    endcase
  end

  assign ok_fire  = cmd_valid && (op != OP_NOP) && legal;
  assign bad_fire = cmd_valid && (op != OP_NOP) && !legal;
  assign take     = ok_fire && (op == OP_ALLOC);
  assign give     = ok_fire && (op == OP_RELEASE);

  always_comb begin
    tgt_cmd        = '0;
    tgt_cmd.load   = take;
    tgt_cmd.arrive = ok_fire && (op == OP_ARRIVE);
    tgt_cmd.leave  = ok_fire && (op == OP_LEAVE);
    tgt_cmd.rearm  = ok_fire && (op == OP_REARM);
    tgt_cmd.clear  = give;
  end

endmodule

// File: rtl/wg_barrier_pool.sv
module wg_barrier_pool
  import wgb_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int MAX_WAVES = 16,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int SID_W    = IDX_W + 1,
  localparam int CNT_W    = $clog2(MAX_WAVES + 1),
  localparam int FC_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [SID_W-1:0]     cmd_id,
  input  logic [CNT_W-1:0]     cmd_count,
  output logic                 grant_valid,
  output logic [SID_W-1:0]     grant_id,
  input  logic [SID_W-1:0]     q_id,
  output logic                 q_allocated,
  output logic [CNT_W-1:0]     q_arrived,
  output logic [CNT_W-1:0]     q_limit,
  output logic [CNT_W-1:0]     q_missing,
  output logic [NUM_SLOTS-1:0] sat_vec,
  output logic [FC_W-1:0]      free_count,
  output logic                 err_sticky
);

  localparam logic [SID_W-1:0] NONE_ID = '1;
  localparam logic [SID_W-1:0] NSLOT   = SID_W'(NUM_SLOTS);

  function automatic logic [CNT_W-1:0] still_out(input logic [CNT_W-1:0] lim,
                                                 input logic [CNT_W-1:0] arr);
    return lim - arr;
  endfunction

  logic [NUM_SLOTS-1:0] free_mask;
  logic                 any_free;
  logic [IDX_W-1:0]     low_idx;
  logic [CNT_W-1:0]     arr_q [NUM_SLOTS];
  logic [CNT_W-1:0]     lim_q [NUM_SLOTS];
  logic [IDX_W-1:0]     tgt_idx;
  wgb_slot_cmd_t        tgt_cmd;
  logic                 ok_fire, bad_fire, take, give;

  // named events for the checker
  logic alloc_fire;
  assign alloc_fire = take;

  wgb_free_pool #(
    .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .FC_W(FC_W)
  ) u_pool (
    .clk(clk), .rst_n(rst_n), .take(take), .give(give),
    .give_idx(cmd_id[IDX_W-1:0]), .free_mask(free_mask),
    .any_free(any_free), .low_idx(low_idx), .free_count(free_count)
  );

  wgb_decode #(
    .NUM_SLOTS(NUM_SLOTS), .MAX_WAVES(MAX_WAVES), .SID_W(SID_W),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_dec (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id),
    .cmd_count(cmd_count), .free_mask(free_mask), .any_free(any_free),
    .low_idx(low_idx), .tgt_arrived(arr_q[cmd_id[IDX_W-1:0]]),
    .tgt_limit(lim_q[cmd_id[IDX_W-1:0]]), .tgt_idx(tgt_idx),
    .tgt_cmd(tgt_cmd), .ok_fire(ok_fire), .bad_fire(bad_fire),
    .take(take), .give(give)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    wgb_slot_cmd_t my_cmd;
    assign my_cmd = (tgt_idx == IDX_W'(g)) ? tgt_cmd : '0;

    wgb_slot #(.CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .cmd(my_cmd), .load_val(cmd_count),
      .arrived(arr_q[g]), .limit(lim_q[g])
    );

    assign sat_vec[g] = !free_mask[g] && (arr_q[g] == lim_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_id    <= NONE_ID;
      err_sticky  <= 1'b0;
    end else begin
      grant_valid <= take;
      if (take) grant_id <= SID_W'(low_idx);
      else if (bad_fire && wgb_op_e'(cmd_op) == OP_ALLOC && !any_free)
        grant_id <= NONE_ID;
      if (bad_fire) err_sticky <= 1'b1;
    end
  end

  logic             q_in;
  logic [IDX_W-1:0] q_idx;
  assign q_in        = (q_id < NSLOT);
  assign q_idx       = q_id[IDX_W-1:0];
  assign q_allocated = q_in && !free_mask[q_idx];
  assign q_arrived   = q_in ? arr_q[q_idx] : '0;
  assign q_limit     = q_in ? lim_q[q_idx] : '0;
  assign q_missing   = still_out(q_limit, q_arrived);

  logic unused_ok;
  assign unused_ok = ok_fire;

endmodule

// File: rtl/wgb_checker.sv
module wgb_checker #(
  parameter int NUM_SLOTS = 4,
  parameter int SID_W     = 3,
  parameter int IDX_W     = 2,
  parameter int CNT_W     = 5,
  parameter int FC_W      = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 grant_valid,
  input logic [SID_W-1:0]     grant_id,
  input logic [SID_W-1:0]     q_id,
  input logic                 q_allocated,
  input logic [CNT_W-1:0]     q_arrived,
  input logic [CNT_W-1:0]     q_limit,
  input logic [NUM_SLOTS-1:0] sat_vec,
  input logic [FC_W-1:0]      free_count,
  input logic                 err_sticky,
  input logic                 alloc_fire,
  input logic                 bad_fire
);

  localparam logic [SID_W-1:0] NSLOT = SID_W'(NUM_SLOTS);

  AST_GRANT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (grant_id != '1 && grant_id < NSLOT)); // R3
  AST_ALLOC_TAKES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (free_count + FC_W'(1)) == $past(free_count)); // R2
  AST_ALLOC_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> grant_valid); // R2
  AST_BAD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_fire |=> ($stable(free_count) && $stable(sat_vec) && !grant_valid)); // R10
  AST_BAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_fire |=> err_sticky); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky); // R11
  AST_ARR_LE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    q_arrived <= q_limit); // R7
  AST_SAT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (q_allocated && q_arrived == q_limit) |-> sat_vec[q_id[IDX_W-1:0]]); // R5

endmodule

bind wg_barrier_pool wgb_checker #(
  .NUM_SLOTS(NUM_SLOTS), .SID_W(SID_W), .IDX_W(IDX_W),
  .CNT_W(CNT_W), .FC_W(FC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grant_valid(grant_valid), .grant_id(grant_id),
  .q_id(q_id), .q_allocated(q_allocated), .q_arrived(q_arrived),
  .q_limit(q_limit), .sat_vec(sat_vec), .free_count(free_count),
  .err_sticky(err_sticky), .alloc_fire(alloc_fire), .bad_fire(bad_fire)
);

// File: tb/tb_wg_barrier_pool.sv
module tb_wg_barrier_pool;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [2:0] cmd_id = 3'd0;
  logic [4:0] cmd_count = 5'd0;
  logic [2:0] q_id = 3'd0;
  logic       grant_valid, q_allocated, err_sticky;
  logic [2:0] grant_id, free_count;
  logic [4:0] q_arrived, q_limit, q_missing;
  logic [NS-1:0] sat_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wg_barrier_pool #(.NUM_SLOTS(NS), .MAX_WAVES(16)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_id(cmd_id), .cmd_count(cmd_count), .grant_valid(grant_valid),
    .grant_id(grant_id), .q_id(q_id), .q_allocated(q_allocated),
    .q_arrived(q_arrived), .q_limit(q_limit), .q_missing(q_missing),
    .sat_vec(sat_vec), .free_count(free_count), .err_sticky(err_sticky)
  );

  typedef struct packed {
    logic [2:0] op;  logic [2:0] id;  logic [4:0] cnt; logic [2:0] qid;
    logic       gv;  logic [2:0] gid; logic [4:0] arr; logic [4:0] lim;
    logic [4:0] miss; logic      sat; logic [2:0] fr;
  } vec_t;

  // op: 0 none, 1 allocate, 2 arrive, 3 leave, 4 re-arm, 5 free
  localparam vec_t TBL [12] = '{
    '{3'd1, 3'd0, 5'd3, 3'd0, 1'b1, 3'd0, 5'd0, 5'd3, 5'd3, 1'b0, 3'd3},
    '{3'd1, 3'd0, 5'd2, 3'd1, 1'b1, 3'd1, 5'd0, 5'd2, 5'd2, 1'b0, 3'd2},
    '{3'd2, 3'd0, 5'd0, 3'd0, 1'b0, 3'd1, 5'd1, 5'd3, 5'd2, 1'b0, 3'd2},
    '{3'd2, 3'd0, 5'd0, 3'd0, 1'b0, 3'd1, 5'd2, 5'd3, 5'd1, 1'b0, 3'd2},
    '{3'd2, 3'd1, 5'd0, 3'd1, 1'b0, 3'd1, 5'd1, 5'd2, 5'd1, 1'b0, 3'd2},
    '{3'd3, 3'd0, 5'd0, 3'd0, 1'b0, 3'd1, 5'd2, 5'd2, 5'd0, 1'b1, 3'd2},
    '{3'd4, 3'd0, 5'd0, 3'd0, 1'b0, 3'd1, 5'd0, 5'd2, 5'd2, 1'b0, 3'd2},
    '{3'd5, 3'd1, 5'd0, 3'd1, 1'b0, 3'd1, 5'd0, 5'd0, 5'd0, 1'b0, 3'd3},
    '{3'd1, 3'd0, 5'd1, 3'd1, 1'b1, 3'd1, 5'd0, 5'd1, 5'd1, 1'b0, 3'd2},
    '{3'd2, 3'd1, 5'd0, 3'd1, 1'b0, 3'd1, 5'd1, 5'd1, 5'd0, 1'b1, 3'd2},
    '{3'd3, 3'd1, 5'd0, 3'd1, 1'b0, 3'd1, 5'd0, 5'd0, 5'd0, 1'b1, 3'd2},
    '{3'd0, 3'd0, 5'd0, 3'd0, 1'b0, 3'd1, 5'd0, 5'd2, 5'd2, 1'b0, 3'd2}
  };

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [2:0] id,
                     input logic [4:0] cnt, input logic [2:0] qid);
    cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_count = cnt; q_id = qid;
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_op = 3'd0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; q_id = 3'd0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 grant_valid", grant_valid, 0);
    chk("R1 grant_id", grant_id, 7);
    chk("R1 free_count", free_count, NS);
    chk("R1 err", err_sticky, 0);
    chk("R1 sat_vec", sat_vec, 0);

    for (int i = 0; i < 12; i++) begin
      cmd(TBL[i].op, TBL[i].id, TBL[i].cnt, TBL[i].qid);
      chk($sformatf("R2 row%0d grant_valid", i), grant_valid, TBL[i].gv);
      chk($sformatf("R2 row%0d grant_id", i), grant_id, TBL[i].gid);
      chk($sformatf("R4/R8 row%0d arrived", i), q_arrived, TBL[i].arr);
      chk($sformatf("R7/R8 row%0d limit", i), q_limit, TBL[i].lim);
      chk($sformatf("R6 row%0d missing", i), q_missing, TBL[i].miss);
      chk($sformatf("R5 row%0d sat", i), sat_vec[TBL[i].qid[1:0]], TBL[i].sat);
      chk($sformatf("R2/R9 row%0d free", i), free_count, TBL[i].fr);
      chk($sformatf("R10 row%0d err", i), err_sticky, 0);
    end

    // R4: arrive on slot 1 whose arrived count equals its limit (0/0)
    cmd(3'd2, 3'd1, 5'd0, 3'd1);
    chk("R4 full arrive err", err_sticky, 1);
    chk("R4 full arrive arrived", q_arrived, 0);
    chk("R4 full arrive sat", sat_vec[1], 1);
    // R11: a later legal command keeps the flag
    cmd(3'd4, 3'd0, 5'd0, 3'd0);
    chk("R11 err held", err_sticky, 1);

    // R3: exhaust the pool
    do_reset();
    for (int k = 0; k < NS; k++) begin
      cmd(3'd1, 3'd0, 5'd1, 3'(k));
      chk("R2 exhaust grant_id", grant_id, k);
      chk("R2 exhaust limit", q_limit, 1);
    end
    chk("R3 pool empty", free_count, 0);
    cmd(3'd1, 3'd0, 5'd1, 3'd0);
    chk("R3 empty grant_valid", grant_valid, 0);
    chk("R3 empty grant_id", grant_id, 7);
    chk("R3 empty err", err_sticky, 1);
    chk("R3 empty free", free_count, 0);

    // R10: reserved ID and unallocated slot
    do_reset();
    cmd(3'd1, 3'd0, 5'd2, 3'd0);
    cmd(3'd2, 3'd7, 5'd0, 3'd0);
    chk("R10 id all-ones err", err_sticky, 1);
    chk("R10 id all-ones arrived", q_arrived, 0);
    chk("R10 id all-ones grant_id", grant_id, 0);
    do_reset();
    cmd(3'd1, 3'd0, 5'd2, 3'd0);
    cmd(3'd2, 3'd2, 5'd0, 3'd2);
    chk("R10 unallocated err", err_sticky, 1);
    chk("R10 unallocated arrived", q_arrived, 0);
    chk("R10 unallocated free", free_count, 3);

    // R7: leave at limit zero
    do_reset();
    cmd(3'd1, 3'd0, 5'd0, 3'd0);
    chk("R7 zero alloc err", err_sticky, 0);
    cmd(3'd3, 3'd0, 5'd0, 3'd0);
    chk("R7 leave at zero err", err_sticky, 1);
    chk("R7 leave at zero limit", q_limit, 0);

    // R10: count too large, unknown op
    do_reset();
    cmd(3'd1, 3'd0, 5'd20, 3'd0);
    chk("R10 big count err", err_sticky, 1);
    chk("R10 big count grant", grant_valid, 0);
    chk("R10 big count free", free_count, NS);
    do_reset();
    cmd(3'd1, 3'd0, 5'd4, 3'd0);
    cmd(3'd7, 3'd0, 5'd0, 3'd0);
    chk("R10 unknown op err", err_sticky, 1);
    chk("R10 unknown op limit", q_limit, 4);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule